// File: doc/BRIEF.md
# Serial Byte Transmitter with Forced Parity

This block turns one byte at a time into an asynchronous serial frame on a single output line. Software writes a byte into a one-entry holding register. When the shift stage is free, the byte moves into it, and the line then carries the frame in this order:

- a low start bit;
- 5 to 8 data bits, least significant first;
- an optional parity bit;
- one or two high stop bits.

Each bit lasts a fixed number of pulses of an external oversampling enable. The default is 16.

Parity can be turned off. When it is on, it can be odd, even, or held at a fixed level. A break input pulls the line low for as long as it is set. Break does not stop the frame in progress: that frame keeps running inside the block while the pin stays low. Two flags tell the writer whether the holding register and the shift stage are empty.

The frame settings (length, stop count, parity controls) are captured when a byte enters the shift stage. The settings may therefore change for the next byte while the current frame is still going out.

Top module: `uart_tx_stick`

## Requirements
- R1: After reset, `tx` is 1, `thr_empty` is 1 and `tsr_empty` is 1.
- R2: A frame begins with one start bit at 0. The data bits follow, least significant bit first. Their count is 5 + `wlen`: code 0 gives 5 bits and code 3 gives 8 bits.
- R3: Every bit of a frame lasts exactly OVS `baud_tick` pulses. The shift stage changes phase only on a pulse.
- R4: When `par_en` is 0, no parity bit is sent, whatever `par_even` and `par_stick` hold.
- R5: When `par_en` is 1 and `par_stick` is 0, `par_even` = 0 gives odd parity and `par_even` = 1 gives even parity, both counted over the data bits sent.
- R6: When `par_en` is 1 and `par_stick` is 1, the parity bit is always 1 if `par_even` is 0, and always 0 if `par_even` is 1.
- R7: The frame ends with one stop bit at 1 when `stop2` is 0, and with two stop bits at 1 when `stop2` is 1.
- R8: While `brk` is 1, `tx` is 0. `tx` follows the normal line value again once `brk` returns to 0.
- R9: A break does not cancel the frame in progress. The shift stage finishes that frame and `tsr_empty` rises, and the next frame goes out intact.
- R10: `thr_empty` is 0 in the cycle after a write. It returns to 1 in the cycle after the byte moves into the shift stage.
- R11: `tsr_empty` falls when a byte moves into the shift stage and rises after the last stop bit. A byte waiting in the holding register is then sent next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Oversampling enable, one pulse per 1/OVS of a bit |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to send |
| wlen | input | 2 | Data length code (5 + code bits) |
| stop2 | input | 1 | Two stop bits when 1 |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | Even select, or fixed level select when par_stick is 1 |
| par_stick | input | 1 | Forced parity enable |
| brk | input | 1 | Break: hold the line low |
| tx | output | 1 | Serial line |
| thr_empty | output | 1 | Holding register empty |
| tsr_empty | output | 1 | Shift stage idle |

## Verification
The bench builds the block with OVS = 4 and drives `baud_tick` on one clock in three. A frame therefore takes about a hundred clocks, which makes room for every length code, every parity mode and both stop counts in one short run. Because pulses arrive on only one clock in three, the bench sees cycles in which the shift stage must hold its phase. The short bit time also lets a break span the whole rest of a frame and still finish quickly.

// File: rtl/uart_tx_stick.sv
module uart_tx_stick #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [1:0] wlen,
  input  logic       stop2,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic       brk,
  output logic       tx,
  output logic       thr_empty,
  output logic       tsr_empty
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] TLAST = CW'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t        st;
  logic [7:0] hold, shf;
  logic       hold_full;
  logic [2:0] bidx, last_idx;
  logic       par_on, par_bit, two_stop, stop_idx;
  logic [CW-1:0] tcnt;
  logic       line;

  wire       load    = (st == S_IDLE) && hold_full;
  wire       bit_end = baud_tick && (tcnt == TLAST);
  wire [7:0] mask    = 8'hFF >> (2'd3 - wlen);
  wire       ones    = ^(hold & mask);
  wire       par_nx  = par_stick ? ~par_even : (par_even ? ones : ~ones);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
    end else if (wr_en) begin
      hold      <= wr_data;
      hold_full <= 1'b1;
    end else if (load) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         tcnt <= '0;
    else if (load)                      tcnt <= '0;
    else if (st != S_IDLE && baud_tick) tcnt <= bit_end ? '0 : tcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      shf      <= '0;
      bidx     <= '0;
      last_idx <= 3'd7;
      par_on   <= 1'b0;
      par_bit  <= 1'b0;
      two_stop <= 1'b0;
      stop_idx <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (load) begin
          shf      <= hold;
          last_idx <= {1'b0, wlen} + 3'd4;
          par_on   <= par_en;
          par_bit  <= par_nx;
          two_stop <= stop2;
          st       <= S_START;
        end
        S_START: if (bit_end) begin
          bidx <= '0;
          st   <= S_DATA;
        end
        S_DATA: if (bit_end) begin
          shf <= shf >> 1;
          if (bidx == last_idx) begin
            stop_idx <= 1'b0;
            st       <= par_on ? S_PAR : S_STOP;
          end else begin
            bidx <= bidx + 3'd1;
          end
        end
        S_PAR: if (bit_end) begin
          stop_idx <= 1'b0;
          st       <= S_STOP;
        end
        S_STOP: if (bit_end) begin
          if (two_stop && !stop_idx) stop_idx <= 1'b1;
          else                       st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_START: line = 1'b0;
      S_DATA:  line = shf[0];
      S_PAR:   line = par_bit;
      default: line = 1'b1;
    endcase
  end

  assign tx        = line & ~brk;
  assign thr_empty = ~hold_full;
  assign tsr_empty = (st == S_IDLE);

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && !brk) |-> !tx); // R2
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA) |-> (bidx <= last_idx)); // R2
  AST_HOLD_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && !baud_tick) |=> $stable(st)); // R3
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP && !brk) |-> tx); // R7
  AST_BRK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !tx); // R8
  AST_THR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !thr_empty); // R10
  AST_LOAD_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!thr_empty && tsr_empty && !wr_en) |=> (thr_empty && !tsr_empty)); // R11
endmodule

// File: tb/sim_uart_tx_stick.sv
module sim_uart_tx_stick;
  localparam int OVS = 4;
  localparam int TD  = 3;
  localparam int BITCLK = OVS * TD;

  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] wlen = 2'd3;
  logic stop2 = 0, par_en = 0, par_even = 0, par_stick = 0, brk = 0;
  logic tx, thr_empty, tsr_empty;

  int n_chk = 0, n_bad = 0;
  bit mon_en = 1'b1;
  logic [11:0] q_bits[$];
  int          q_len[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  uart_tx_stick #(.OVS(OVS)) u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
    .wlen(wlen), .stop2(stop2), .par_en(par_en), .par_even(par_even),
    .par_stick(par_stick), .brk(brk), .tx(tx), .thr_empty(thr_empty), .tsr_empty(tsr_empty));

  int tdiv = 0;
  always @(negedge clk) begin
    tdiv      <= (tdiv == TD - 1) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == TD - 1);
  end

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] wl, input logic s2,
                      input logic pe, input logic ev, input logic sk, input bit push,
                      input string tag);
    logic [11:0] b;
    int n, cnt;
    while (!thr_empty) @(negedge clk);
    b = '0; n = 1; cnt = 0;
    for (int i = 0; i < 5 + int'(wl); i++) begin
      b[n] = d[i]; cnt += d[i]; n++;
    end
    if (pe) begin
      b[n] = sk ? ~ev : (ev ? cnt[0] : ~cnt[0]);
      n++;
    end
    b[n] = 1'b1; n++;
    if (s2) begin b[n] = 1'b1; n++; end
    if (push) begin q_bits.push_back(b); q_len.push_back(n); q_tag.push_back(tag); end
    wlen = wl; stop2 = s2; par_en = pe; par_even = ev; par_stick = sk;
    wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin : monitor
    logic prev;
    logic [11:0] got, exp;
    int n;
    string tag;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (mon_en && rst_n && prev && !tx) begin
        if (q_len.size() == 0) begin
          chk("R2 unexpected start", 12'd1, 12'd0);
        end else begin
          exp = q_bits.pop_front(); n = q_len.pop_front(); tag = q_tag.pop_front();
          got = '0;
          repeat (BITCLK / 2) @(negedge clk);
          for (int i = 0; i < n; i++) begin
            got[i] = tx;
            if (i != n - 1) repeat (BITCLK) @(negedge clk);
          end
          chk(tag, got, exp);
        end
        prev = 1'b1;
      end else begin
        prev = tx;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(negedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    chk("R1 reset flags", {9'd0, tx, thr_empty, tsr_empty}, 12'h007);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    send(8'h5A, 2'd3, 0, 0, 0, 0, 1, "R2 8-bit frame");
    chk("R10 thr_empty low after write", {11'd0, thr_empty}, 12'd0);
    @(negedge clk);
    chk("R11 moved to shifter", {10'd0, thr_empty, tsr_empty}, 12'b10);
    send(8'hC3, 2'd3, 0, 0, 0, 0, 1, "R11 queued byte");
    chk("R10 holding full while busy", {11'd0, thr_empty}, 12'd0);

    send(8'h15, 2'd0, 0, 0, 0, 0, 1, "R2 5-bit frame");
    send(8'h2B, 2'd1, 0, 0, 0, 0, 1, "R2 6-bit frame");
    send(8'h6E, 2'd2, 1, 0, 0, 0, 1, "R7 7-bit two stop");
    send(8'hF0, 2'd3, 0, 0, 1, 1, 1, "R4 parity off ignores stick");
    send(8'h07, 2'd3, 0, 1, 0, 0, 1, "R5 odd parity");
    send(8'h07, 2'd3, 0, 1, 1, 0, 1, "R5 even parity");
    send(8'h1F, 2'd0, 1, 1, 0, 0, 1, "R5 odd 5-bit two stop");
    send(8'h81, 2'd3, 0, 1, 0, 1, 1, "R6 forced one");
    send(8'h80, 2'd3, 1, 1, 1, 1, 1, "R6 forced zero");
    send(8'hFF, 2'd1, 0, 1, 1, 0, 1, "R5 even 6-bit");

    while (!(tsr_empty && thr_empty && q_len.size() == 0)) @(negedge clk);
    repeat (BITCLK) @(negedge clk);
    chk("R11 idle after last stop", {10'd0, tx, tsr_empty}, 12'b11);

    mon_en = 1'b0;
    send(8'hA5, 2'd3, 1, 1, 0, 0, 0, "");
    repeat (2 * BITCLK) @(negedge clk);
    brk = 1'b1;
    @(negedge clk);
    chk("R8 break drives low", {11'd0, tx}, 12'd0);
    chk("R9 frame still running", {11'd0, tsr_empty}, 12'd0);
    begin : wait_end
      int t;
      t = 0;
      while (!tsr_empty && t < 40 * BITCLK) begin @(negedge clk); t++; end
    end
    chk("R9 shifter finished under break", {11'd0, tsr_empty}, 12'd1);
    chk("R8 still low after frame", {11'd0, tx}, 12'd0);
    repeat (5) @(negedge clk);
    brk = 1'b0;
    @(negedge clk);
    chk("R8 line released", {11'd0, tx}, 12'd1);
    mon_en = 1'b1;
    repeat (4) @(negedge clk);
    send(8'h3C, 2'd3, 0, 1, 1, 0, 1, "R9 frame after break");
    while (!(tsr_empty && thr_empty && q_len.size() == 0)) @(negedge clk);
    repeat (BITCLK) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule